// File: doc/BRIEF.md
# Serial Controller Interrupt Event Generator

This block sits beside a serial controller and turns its raw status into a single interrupt request. Nine sources feed it: three FIFO status levels (receive data valid, transmit space free, transmit idle), four DMA buffer-active flags (receive A/B, transmit A/B) and two single-cycle error pulses (receive overrun, transmit underrun). Each source owns one pending bit. The bits are masked by a per-source enable register and then combined into one request, which is gated by a top-level enable.

A mode input selects how the three FIFO sources behave. In edge mode they latch on a 0 to 1 transition. In level mode they follow the source. A DMA source always latches when its buffer-active flag falls. An error source latches on any cycle its pulse is high. Software uses one write port for two jobs: it loads the enable register, and it clears pending bits by writing ones to them.

Top module: `serial_irq_gen`

## Requirements
- R1: After reset, `pending` and `enable` read all zeros and `irq` is low.
- R2: In edge mode (`level_mode`=0), a 0 to 1 change on `rx_valid`, `tx_free` or `tx_idle` sets that source's pending bit at the next clock edge. The bit stays set after the source returns low.
- R3: A write with `wr_sel`=1 clears each pending bit whose `wr_data` bit is 1. Pending bits whose `wr_data` bit is 0 are unchanged.
- R4: In level mode (`level_mode`=1), pending bits 2:0 equal the FIFO source levels sampled at the previous clock edge. A clear write has no lasting effect on a bit whose source is still high.
- R5: A DMA pending bit is set one edge after its buffer-active flag falls from 1 to 0. A rise of the flag sets nothing.
- R6: A high cycle on `rx_overrun` or `tx_underrun` sets that source's pending bit at the clock edge that samples it.
- R7: `irq` is high exactly when `top_en` is 1 and at least one pending bit has its enable bit set.
- R8: A write with `wr_sel`=0 replaces the whole `enable` register with `wr_data`. The register is readable on `enable`.
- R9: If a source event and a clear of the same bit arrive in one cycle, the bit ends up set.
- R10: The bit order of `pending`, `enable` and `wr_data` is fixed:
  - 0 `rx_valid`
  - 1 `tx_free`
  - 2 `tx_idle`
  - 3 receive DMA A
  - 4 receive DMA B
  - 5 transmit DMA A
  - 6 transmit DMA B
  - 7 receive overrun
  - 8 transmit underrun

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| level_mode | input | 1 | 1 = FIFO sources level-triggered, 0 = rising-edge |
| top_en | input | 1 | Top-level interrupt enable |
| rx_valid | input | 1 | Receive FIFO holds data |
| tx_free | input | 1 | Transmit FIFO has space |
| tx_idle | input | 1 | Transmit FIFO empty and shifter done |
| rx_dma_act_a | input | 1 | Receive DMA buffer A active |
| rx_dma_act_b | input | 1 | Receive DMA buffer B active |
| tx_dma_act_a | input | 1 | Transmit DMA buffer A active |
| tx_dma_act_b | input | 1 | Transmit DMA buffer B active |
| rx_overrun | input | 1 | Receive overrun error pulse |
| tx_underrun | input | 1 | Transmit underrun error pulse |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = load enables, 1 = clear pending by ones |
| wr_data | input | 9 | Write data, bit order per R10 |
| pending | output | 9 | Pending bits, bit order per R10 |
| enable | output | 9 | Enable register, bit order per R10 |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench raises a DMA flag before dropping it. A design that detected the wrong edge would set the bit on the rise, or set nothing. It drops a FIFO source after its edge; a design that treated edge mode as level would lose the bit. It clears a bit in the same cycle its source fires; a design that gave the clear priority would lose that event. In level mode it writes a clear while the source is still high and checks that the bit survives. With pending bits present, it removes first `top_en` and then the matching enable, so a design that skipped either gate would keep `irq` high.

// File: rtl/serial_irq_gen.sv
module serial_irq_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level_mode,
  input  logic       top_en,
  input  logic       rx_valid,
  input  logic       tx_free,
  input  logic       tx_idle,
  input  logic       rx_dma_act_a,
  input  logic       rx_dma_act_b,
  input  logic       tx_dma_act_a,
  input  logic       tx_dma_act_b,
  input  logic       rx_overrun,
  input  logic       tx_underrun,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [8:0] wr_data,
  output logic [8:0] pending,
  output logic [8:0] enable,
  output logic       irq
);
  localparam int NSRC  = 9;
  localparam int NFIFO = 3;
  localparam int NDMA  = 4;
  localparam int NHIST = NFIFO + NDMA;

  logic [NSRC-1:0]  src;
  logic [NHIST-1:0] prev_q;
  logic [NSRC-1:0]  pend_q, pend_d, en_q, clr, hit;

  assign src = {tx_underrun, rx_overrun, tx_dma_act_b, tx_dma_act_a,
                rx_dma_act_b, rx_dma_act_a, tx_idle, tx_free, rx_valid};

  assign hit[NFIFO-1:0]          = src[NFIFO-1:0] & ~prev_q[NFIFO-1:0];
  assign hit[NHIST-1:NFIFO]      = ~src[NHIST-1:NFIFO] & prev_q[NHIST-1:NFIFO];
  assign hit[NSRC-1:NHIST]       = src[NSRC-1:NHIST];

  assign clr = (wr_en && wr_sel) ? wr_data : '0;

  always_comb begin
    pend_d = (pend_q & ~clr) | hit;
    if (level_mode) pend_d[NFIFO-1:0] = src[NFIFO-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      prev_q <= '0;
    end else begin
      pend_q <= pend_d;
      prev_q <= src[NHIST-1:0];
      if (wr_en && !wr_sel) en_q <= wr_data;
    end
  end

  assign pending = pend_q;
  assign enable  = en_q;
  assign irq     = top_en & |(pend_q & en_q);
endmodule

// File: rtl/serial_irq_gen_chk.sv
module serial_irq_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       level_mode,
  input logic       top_en,
  input logic       rx_valid,
  input logic       tx_free,
  input logic       tx_idle,
  input logic       rx_dma_act_a,
  input logic       rx_overrun,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [8:0] pending,
  input logic [8:0] enable,
  input logic       irq
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (pending == '0 && enable == '0));

  assert_edge_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && pending[0] && !(wr_en && wr_sel)) |=> pending[0]);

  assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    level_mode |=> pending[2:0] == $past({tx_idle, tx_free, rx_valid}));

  assert_dma_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_dma_act_a) |=> pending[3]);

  assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> pending[7]);

  assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !top_en |-> !irq);

  assert_gate_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (top_en && pending[7] && enable[7]) |-> irq);
endmodule

bind serial_irq_gen serial_irq_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .level_mode(level_mode), .top_en(top_en),
  .rx_valid(rx_valid), .tx_free(tx_free), .tx_idle(tx_idle),
  .rx_dma_act_a(rx_dma_act_a), .rx_overrun(rx_overrun),
  .wr_en(wr_en), .wr_sel(wr_sel), .pending(pending), .enable(enable), .irq(irq)
);

// File: tb/serial_irq_gen_bench.sv
module serial_irq_gen_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic level_mode = 0, top_en = 0;
  logic rx_valid = 0, tx_free = 0, tx_idle = 0;
  logic rx_dma_act_a = 0, rx_dma_act_b = 0, tx_dma_act_a = 0, tx_dma_act_b = 0;
  logic rx_overrun = 0, tx_underrun = 0;
  logic wr_en = 0, wr_sel = 0;
  logic [8:0] wr_data = '0;
  logic [8:0] pending, enable;
  logic irq;

  always #2 clk = ~clk;

  serial_irq_gen u_serial_irq_gen (.*);

  typedef struct { logic [8:0] pend; logic [8:0] en; logic irq; string req; } item_t;
  item_t q[$];
  int total = 0, bad = 0;
  logic [8:0] m_pend = '0, m_en = '0;
  logic [6:0] m_prev = '0;
  bit done = 0;

  task automatic check(string req, logic [8:0] ap, logic [8:0] ep,
                       logic [8:0] ae, logic [8:0] ee, logic ai, logic ei);
    total++;
    if (ap !== ep || ae !== ee || ai !== ei) begin
      bad++;
      $display("FAIL %s: pending=%h/%h enable=%h/%h irq=%b/%b (actual/expected)",
               req, ap, ep, ae, ee, ai, ei);
    end
  endtask

  // driver: model the requirements and push the expected result
  task automatic step(string req);
    logic [8:0] s, nxt;
    item_t it;
    s = {tx_underrun, rx_overrun, tx_dma_act_b, tx_dma_act_a,
         rx_dma_act_b, rx_dma_act_a, tx_idle, tx_free, rx_valid};
    nxt = m_pend;
    if (wr_en && wr_sel) nxt = nxt & ~wr_data;
    for (int i = 0; i < 3; i++)
      if (level_mode) nxt[i] = s[i];
      else if (s[i] && !m_prev[i]) nxt[i] = 1'b1;
    for (int i = 3; i < 7; i++) if (!s[i] && m_prev[i]) nxt[i] = 1'b1;
    for (int i = 7; i < 9; i++) if (s[i]) nxt[i] = 1'b1;
    if (wr_en && !wr_sel) m_en = wr_data;
    m_prev = s[6:0];
    m_pend = nxt;
    it.pend = m_pend; it.en = m_en; it.irq = top_en && |(m_pend & m_en); it.req = req;
    q.push_back(it);
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rx_overrun = 0; tx_underrun = 0;
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(it.req, pending, it.pend, enable, it.en, irq, it.irq);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", pending, 9'h000, enable, 9'h000, irq, 1'b0);
    rst_n = 1;
    top_en = 1;
    // R8 load enables
    wr_en = 1; wr_sel = 0; wr_data = 9'h1FF; step("R8");
    // R2 edge mode rise then fall
    rx_valid = 1; step("R2 R10 rx_valid rise");
    rx_valid = 0; step("R2 held after fall");
    tx_free = 1;  step("R2 tx_free rise");
    tx_idle = 1;  step("R2 tx_idle rise");
    // R3 clear selected bits only
    wr_en = 1; wr_sel = 1; wr_data = 9'h001; step("R3 clear bit0");
    wr_en = 1; wr_sel = 1; wr_data = 9'h000; step("R3 zero write");
    wr_en = 1; wr_sel = 1; wr_data = 9'h006; step("R3 clear bits 2:1");
    tx_free = 0; tx_idle = 0; step("R2 no set on fall");
    // R5 DMA edges
    rx_dma_act_a = 1; step("R5 rise no set");
    rx_dma_act_a = 0; step("R5 rx A fall");
    rx_dma_act_b = 1; tx_dma_act_a = 1; tx_dma_act_b = 1; step("R5 rises");
    rx_dma_act_b = 0; step("R5 rx B fall");
    tx_dma_act_a = 0; step("R5 tx A fall");
    tx_dma_act_b = 0; step("R5 tx B fall");
    // R6 errors
    rx_overrun = 1; step("R6 overrun");
    tx_underrun = 1; step("R6 underrun");
    wr_en = 1; wr_sel = 1; wr_data = 9'h1FF; step("R3 clear all");
    // R9 set beats clear
    tx_free = 1; wr_en = 1; wr_sel = 1; wr_data = 9'h002; step("R9 set wins");
    wr_en = 1; wr_sel = 1; wr_data = 9'h002; step("R3 clear tx_free");
    tx_free = 0; step("R3 idle");
    // R7 gating
    rx_overrun = 1; step("R7 irq on");
    top_en = 0; step("R7 top gate");
    top_en = 1; wr_en = 1; wr_sel = 0; wr_data = 9'h07F; step("R7 R8 mask bit7");
    wr_en = 1; wr_sel = 0; wr_data = 9'h180; step("R7 unmask");
    wr_en = 1; wr_sel = 1; wr_data = 9'h1FF; step("R3 clear all 2");
    // R4 level mode
    level_mode = 1;
    tx_idle = 1; step("R4 level high");
    wr_en = 1; wr_sel = 1; wr_data = 9'h004; step("R4 clear while high");
    step("R4 still high");
    tx_idle = 0; rx_valid = 1; step("R4 follow");
    rx_valid = 0; step("R4 low");
    level_mode = 0; step("R2 back to edge");
    repeat (3) @(posedge clk);
    #1;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule